// File: doc/BRIEF.md
# Sequential 32-by-16 Integer Divider

This block divides a 32-bit dividend by a 16-bit divisor over several clocks. It works in either unsigned or two's-complement signed mode. The 16-bit quotient and the 16-bit remainder are packed into one 32-bit result word. It also produces condition flags, a write strobe for the destination register, and a one-cycle strobe that requests a divide-by-zero trap.

An operation starts with a one-cycle `start_i` pulse while the block is idle. In the next cycle the block checks for a zero divisor and for a quotient that is certain not to fit. If neither applies, it runs a restoring shift-subtract loop that yields one quotient bit per clock. A final cycle fixes the signs and checks the signed range. `done_o` pulses once at the end of every operation. A trap or an overflow ends the operation with `wr_en_o` low and `result_o` unchanged.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=0), a successful divide gives `result_o[15:0]` = dividend / divisor and `result_o[31:16]` = dividend mod divisor. `wr_en_o` pulses high in the same cycle as `done_o`.
- R2: In signed mode (`signed_i`=1), both operands are two's complement. The quotient truncates toward zero. The remainder is zero or has the sign of the dividend.
- R3: A zero divisor ends the operation with `done_o` and `zdiv_trap_o` high for one cycle. `wr_en_o` stays low, `result_o` keeps its previous value, and the N, Z, V and C flags all read 0.
- R4: If the quotient does not fit in 16 bits, the operation ends with V=1 and N=Z=C=0. `wr_en_o` stays low and `result_o` keeps its previous value. The range is 0..65535 in unsigned mode and -32768..32767 in signed mode.
- R5: After a successful divide, N equals bit 15 of the quotient, Z is 1 exactly when the 16-bit quotient is zero, and V is 0.
- R6: The carry flag C reads 0 after every completed operation.
- R7: `done_o` pulses no later than 140 clocks after the `start_i` edge in unsigned mode, and no later than 158 clocks in signed mode.
- R8: A `start_i` pulse that arrives while an operation is in progress is ignored. That operation completes with its own operands, and no second `done_o` follows.
- R9: While `rst_ni` is low, and after it is released, all outputs read 0.
- R10: In signed mode, a quotient of exactly -32768 is written normally. A quotient of +32768 is an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| signed_i | input | 1 | 1 selects signed mode, 0 selects unsigned mode; sampled with start |
| dividend_i | input | 32 | Dividend; sampled with start |
| divisor_i | input | 16 | Divisor; sampled with start |
| result_o | output | 32 | Remainder in [31:16], quotient in [15:0] |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, always 0 after an operation |
| zdiv_trap_o | output | 1 | One-cycle divide-by-zero trap request |
| wr_en_o | output | 1 | One-cycle destination write enable |
| done_o | output | 1 | One-cycle end-of-operation strobe |

## Verification
The assertions take for granted that `start_i` is a clean synchronous pulse. They also assume that operands presented with a start are stable in that cycle, so that the latched magnitudes and mode stay fixed for the whole loop. The stimulus drives every input on the falling edge and holds `start_i` for exactly one cycle. It waits for `done_o` before the next start, except in the directed test that deliberately pulses `start_i` mid-operation to exercise the ignored-start rule.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RUN,
    ST_FIX
  } div_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } div_flags_t;
endpackage

// File: rtl/div_cneg.sv
module div_cneg #(
  parameter int W = 16
) (
  input  logic         neg_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  always_comb val_o = neg_i ? (~val_i + W'(1)) : val_i;
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [2*QW-1:0] dend_i,
  input  logic [QW-1:0] dvs_i,
  output logic [2*QW-1:0] acc_o
);
  localparam int DW = 2 * QW;

  logic [DW-1:0] acc_q, acc_d;
  logic [QW-1:0] dvs_q;
  logic [DW:0]   shl;
  logic [QW:0]   top, diff;
  logic          ge;

  // acc holds {partial remainder, dividend bits / quotient bits}
  always_comb begin
    shl   = {acc_q, 1'b0};
    top   = shl[DW:QW];
    ge    = top >= {1'b0, dvs_q};
    diff  = top - {1'b0, dvs_q};
    acc_d = ge ? {diff[QW-1:0], shl[QW-1:1], 1'b1} : shl[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      acc_q <= dend_i;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  // restoring invariant: partial remainder stays below divisor (R1)
  assert_partial_rem_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (acc_q[DW-1:QW] < dvs_q));
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int QW      = 16,
  parameter int U_LIMIT = 140,
  parameter int S_LIMIT = 158
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic [2*QW-1:0] dividend_i,
  input  logic [QW-1:0]   divisor_i,
  output logic [2*QW-1:0] result_o,
  output logic            flag_n_o,
  output logic            flag_z_o,
  output logic            flag_v_o,
  output logic            flag_c_o,
  output logic            zdiv_trap_o,
  output logic            wr_en_o,
  output logic            done_o
);
  localparam int DW = 2 * QW;
  localparam int CW = $clog2(QW);
  localparam int LW = $clog2(S_LIMIT + 2);
  localparam logic [QW-1:0] QMIN_MAG = QW'(1) << (QW - 1);

  div_state_e    state_q;
  logic          sgn_q, q_neg_q, r_neg_q;
  logic [DW-1:0] dend_mag_q, dend_mag;
  logic [QW-1:0] dvs_mag_q, dvs_mag;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lat_q;
  logic [DW-1:0] acc;
  logic [QW-1:0] q_fix, r_fix;
  logic          dend_neg, dvs_neg, mag_ovf, sgn_ovf;
  logic [DW-1:0] result_q;
  div_flags_t    flags_q;
  logic          done_q, trap_q, wr_q;

  assign dend_neg = signed_i & dividend_i[DW-1];
  assign dvs_neg  = signed_i & divisor_i[QW-1];

  div_cneg #(.W(DW)) u_dend_abs (.neg_i(dend_neg), .val_i(dividend_i), .val_o(dend_mag));
  div_cneg #(.W(QW)) u_dvs_abs  (.neg_i(dvs_neg),  .val_i(divisor_i),  .val_o(dvs_mag));

  div_core #(.QW(QW)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_CHECK),
    .step_i (state_q == ST_RUN),
    .dend_i (dend_mag_q),
    .dvs_i  (dvs_mag_q),
    .acc_o  (acc)
  );

  div_cneg #(.W(QW)) u_q_fix (.neg_i(q_neg_q), .val_i(acc[QW-1:0]),  .val_o(q_fix));
  div_cneg #(.W(QW)) u_r_fix (.neg_i(r_neg_q), .val_i(acc[DW-1:QW]), .val_o(r_fix));

  // quotient magnitude >= 2^QW: high half of dividend not below divisor
  assign mag_ovf = dend_mag_q[DW-1:QW] >= dvs_mag_q;
  assign sgn_ovf = sgn_q && (q_neg_q ? (acc[QW-1:0] > QMIN_MAG) : acc[QW-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sgn_q      <= 1'b0;
      q_neg_q    <= 1'b0;
      r_neg_q    <= 1'b0;
      dend_mag_q <= '0;
      dvs_mag_q  <= '0;
      cnt_q      <= '0;
      lat_q      <= '0;
      result_q   <= '0;
      flags_q    <= '0;
      done_q     <= 1'b0;
      trap_q     <= 1'b0;
      wr_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      wr_q   <= 1'b0;
      if (state_q != ST_IDLE) lat_q <= lat_q + LW'(1);
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_CHECK;
          sgn_q      <= signed_i;
          q_neg_q    <= dend_neg ^ dvs_neg;
          r_neg_q    <= dend_neg;
          dend_mag_q <= dend_mag;
          dvs_mag_q  <= dvs_mag;
          lat_q      <= LW'(1);
        end
        ST_CHECK: begin
          if (dvs_mag_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            trap_q  <= 1'b1;
            flags_q <= '0;
          end else if (mag_ovf) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
          end else begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(QW - 1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (sgn_ovf) begin
            flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
          end else begin
            wr_q     <= 1'b1;
            result_q <= {r_fix, q_fix};
            flags_q  <= '{n: q_fix[QW-1], z: (q_fix == '0), v: 1'b0, c: 1'b0};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o    = result_q;
  assign flag_n_o    = flags_q.n;
  assign flag_z_o    = flags_q.z;
  assign flag_v_o    = flags_q.v;
  assign flag_c_o    = flags_q.c;
  assign zdiv_trap_o = trap_q;
  assign wr_en_o     = wr_q;
  assign done_o      = done_q;

  assert_trap_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zdiv_trap_o |-> (done_o && !wr_en_o && !flag_v_o));
  assert_no_overflow_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_v_o) |-> !wr_en_o);
  assert_result_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable(result_o));
  assert_write_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (done_o && !flag_v_o && !zdiv_trap_o));
  assert_carry_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !flag_c_o);
  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (lat_q <= (sgn_q ? LW'(S_LIMIT) : LW'(U_LIMIT))));
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> ($stable(sgn_q) && $stable(q_neg_q) && $stable(r_neg_q)));
endmodule

// File: tb/seq_divider_bench.sv
module seq_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] dend = '0;
  logic [15:0] dvs = '0;
  logic [31:0] result;
  logic        fn, fz, fv, fc, trap, wr, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int done_cnt = 0;

  always #4 clk = ~clk;

  seq_divider u_seq_divider (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dend), .divisor_i(dvs), .result_o(result),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc),
    .zdiv_trap_o(trap), .wr_en_o(wr), .done_o(done)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 ok, 1 overflow, 2 zero-divide trap
  // entry: {signed, kind[1:0], dividend[31:0], divisor[15:0]}
  localparam int NV = 17;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'd100,        16'd7},
    {1'b0, 2'd0, 32'h0000_FFFF,  16'd1},
    {1'b0, 2'd1, 32'h0001_0000,  16'd1},
    {1'b0, 2'd1, 32'hFFFF_FFFF,  16'hFFFF},
    {1'b0, 2'd0, 32'hFFFE_FFFF,  16'hFFFF},
    {1'b0, 2'd0, 32'd0,          16'd5},
    {1'b0, 2'd2, 32'd1234,       16'd0},
    {1'b1, 2'd0, 32'hFFFF_FF9C,  16'd7},
    {1'b1, 2'd0, 32'd100,        16'hFFF9},
    {1'b1, 2'd0, 32'hFFFF_FF9C,  16'hFFF9},
    {1'b1, 2'd0, 32'hFFFF_8000,  16'd1},
    {1'b1, 2'd1, 32'h0000_8000,  16'd1},
    {1'b1, 2'd1, 32'h8000_0000,  16'hFFFF},
    {1'b1, 2'd1, 32'h8000_0000,  16'h8000},
    {1'b1, 2'd2, 32'd5,          16'd0},
    {1'b1, 2'd1, 32'h7FFF_FFFF,  16'h7FFF},
    {1'b1, 2'd0, 32'hFFFF_FFFF,  16'd2}
  };

  // pulse start, wait for done; returns clocks from start edge to done
  task automatic run_op(input logic s, input logic [31:0] a, input logic [15:0] b, output int lat);
    @(negedge clk);
    start = 1'b1; sgn = s; dend = a; dvs = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [31:0] prev, exp_res;
    longint qa, ra, na, da;
    #1;
    chk("R9 reset result", result, 32'h0);
    chk("R9 reset strobes", {28'h0, trap, wr, done, fc}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", {result[31:4], fn, fz, fv, trap | wr | done}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic        s;
      logic [1:0]  k;
      logic [31:0] a;
      logic [15:0] b;
      {s, k, a, b} = VEC[i];
      prev = result;
      run_op(s, a, b, lat);
      chk($sformatf("R7 latency v%0d", i), (lat <= (s ? 158 : 140)), 32'd1);
      chk($sformatf("R6 carry v%0d", i), {31'h0, fc}, 32'h0);
      if (k == 2) begin
        chk($sformatf("R3 trap v%0d", i), {29'h0, trap, wr, done}, 32'h5);
        chk($sformatf("R3 flags v%0d", i), {28'h0, fn, fz, fv, fc}, 32'h0);
        chk($sformatf("R3 result held v%0d", i), result, prev);
      end else if (k == 1) begin
        chk($sformatf("R4 overflow v%0d", i), {28'h0, fv, trap, wr, done}, 32'h9);
        chk($sformatf("R4 flags v%0d", i), {30'h0, fn, fz}, 32'h0);
        chk($sformatf("R4 result held v%0d", i), result, prev);
      end else begin
        if (s) begin
          na = longint'($signed(a));
          da = longint'($signed(b));
        end else begin
          na = longint'({32'h0, a});
          da = longint'({48'h0, b});
        end
        qa = na / da;
        ra = na % da;
        exp_res = {ra[15:0], qa[15:0]};
        chk($sformatf("%s value v%0d", s ? "R2" : "R1", i), result, exp_res);
        chk($sformatf("R1 write v%0d", i), {29'h0, trap, wr, done}, 32'h3);
        chk($sformatf("R5 flags v%0d", i), {29'h0, fn, fz, fv},
            {29'h0, qa[15], (qa[15:0] == 16'h0), 1'b0});
      end
    end

    // R10: -32768 written, +32768 overflow (table v10 / v11); recheck values directly
    run_op(1'b1, 32'hFFFF_0000, 16'd2, lat);
    chk("R10 min quotient", result, 32'h0000_8000);
    chk("R10 min write", {31'h0, wr}, 32'h1);
    run_op(1'b1, 32'hFFFF_0000, 16'hFFFE, lat);
    chk("R10 plus 32768 overflow", {30'h0, fv, wr}, 32'h2);

    // R8: second start mid-operation is ignored
    @(negedge clk);
    start = 1'b1; sgn = 1'b0; dend = 32'd1000; dvs = 16'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; sgn = 1'b1; dend = 32'd77; dvs = 16'd0;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    begin
      int d0;
      d0 = done_cnt;
      while (!done && lat < 1000) begin
        @(negedge clk);
        lat++;
      end
      chk("R8 first op result", result, {16'd1, 16'd333});
      chk("R8 no trap from ignored start", {31'h0, trap}, 32'h0);
      repeat (40) @(negedge clk);
      chk("R8 single done", done_cnt - d0, 32'd1);
    end

    // R9: reset mid-operation clears outputs
    @(negedge clk);
    start = 1'b1; sgn = 1'b0; dend = 32'd50; dvs = 16'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset mid-op", {result[31:4], fn, fz, fv, done}, 32'h0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9 no done after reset", {31'h0, done}, 32'h0);

    summary();
    $finish;
  end
endmodule